// File: doc/BRIEF.md
# Scan-Chain Debug Bus Bridge

This block turns traffic on one scan chain of a test access port into transfers on a small debug bus. The bus has an 8-bit address, 64-bit write data, 64-bit read data, a request, a write flag and an acknowledge. The TAP state machine is not part of this block. Its strobes (capture, shift, update), the chain-select code, TDI and the TCK clock arrive as plain inputs, and the block drives TDO.

A host exchanges one 74-bit word per scan. The word carries a 2-bit op field, then a 64-bit data field, then an 8-bit address field, and it enters least significant bit first. On update, a read or write op is handed to the system clock domain. On the next capture, the op field reports whether that command has finished. If it has, the data field holds the read data. The host keeps scanning until the status shows done.

Each domain has its own small state machine. The TCK side has two states. In `T_IDLE`, an update carrying a read or write op moves it to `T_PEND` and flips a request toggle. In `T_PEND`, it returns to `T_IDLE` once the synchronised acknowledge toggle matches the request toggle. The system side has three states. In `S_IDLE`, a change of the synchronised request toggle loads the bus and moves it to `S_WAIT`. In `S_WAIT`, the bus acknowledge drops the request and moves it to `S_DONE`. `S_DONE` flips the acknowledge toggle and returns to `S_IDLE`.

Top module: `jtag_dbg_bridge`

## Requirements
- R1: The scan register is 74 bits wide. It shifts toward TDO on each TCK edge with shift asserted, and TDO is the current bit 0. Bits [1:0] hold the op, bits [65:2] hold the data and bits [73:66] hold the address, so the op leaves and enters first. On capture, the address field shows the address of the last launched command.
- R2: An update with op 2'b01 launches a bus read, and an update with op 2'b10 launches a bus write (dbus_we=1), using the shifted address and data.
- R3: When no command is outstanding, capture loads status 2'b00 into the op field and the data returned by the last completed read into the data field.
- R4: While a command is outstanding, including while its completion is crossing back to TCK, capture loads status 2'b11.
- R5: Capture, shift and update act only when chain_sel equals 4'd2. On any other chain, TDO does not change and no bus request is made.
- R6: An update with op 2'b00 or 2'b11 launches no bus request and leaves the last launched address unchanged.
- R7: An update that arrives while a command is outstanding is ignored, and the status stays 2'b11.
- R8: dbus_addr, dbus_wdata and dbus_we hold steady from the rise of dbus_req until the acknowledge cycle. dbus_req falls in the cycle after dbus_ack.
- R9: trst clears the TCK side, so TDO becomes 0 and the status becomes idle. sys_rst, which is synchronous, clears dbus_req.
- R10: The read data returned through the scan equals the dbus_rdata sampled with the acknowledge. The write data on the bus equals the shifted data field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| trst | input | 1 | Scan-side reset, active high, synchronous to tck |
| chain_sel | input | 4 | Selected chain code; the block responds to 2 |
| capture | input | 1 | Capture strobe from the TAP |
| shift | input | 1 | Shift enable from the TAP |
| update | input | 1 | Update strobe from the TAP |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (scan register bit 0) |
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | System reset, active high, synchronous |
| dbus_addr | output | 8 | Debug bus address |
| dbus_wdata | output | 64 | Debug bus write data |
| dbus_we | output | 1 | Debug bus write flag |
| dbus_req | output | 1 | Debug bus request |
| dbus_rdata | input | 64 | Debug bus read data |
| dbus_ack | input | 1 | Debug bus acknowledge, one cycle |

## Verification
The bench holds one acknowledge for about ten microseconds so that a second write can be scanned in while the first is still outstanding. A design that accepts that update raises an extra request, and the bus model reports it as unexpected. Status-only scans with op 00 and 11 are mixed in among real commands. A design that launches them, or that overwrites the last address with them, fails the address-field and unexpected-request checks. A full write scan on a foreign chain checks that TDO never moves, which catches a design that decodes the chain select only on update. The read data values differ in every byte, so a field-order or bit-direction mistake shows up as a data mismatch.

// File: rtl/jdb_pkg.sv
`timescale 1ns/1ps
package jdb_pkg;
    typedef enum logic [1:0] {
        OP_NOP  = 2'b00,
        OP_RD   = 2'b01,
        OP_WR   = 2'b10,
        OP_BUSY = 2'b11
    } jdb_op_e;

    typedef enum logic {
        T_IDLE,
        T_PEND
    } tck_state_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_DONE
    } sys_state_e;
endpackage

// File: rtl/jdb_sync.sv
`timescale 1ns/1ps
module jdb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/jdb_scan_path.sv
`timescale 1ns/1ps
module jdb_scan_path #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64,
    localparam int SR_W  = 2 + DATA_W + ADDR_W
) (
    input  logic              tck,
    input  logic              trst,
    input  logic              en,
    input  logic              capture,
    input  logic              shift,
    input  logic              tdi,
    input  logic              cap_busy,
    input  logic [DATA_W-1:0] cap_data,
    input  logic [ADDR_W-1:0] cap_addr,
    output logic [SR_W-1:0]   sr_q,
    output logic              tdo
);
    logic [1:0] cap_status;

    assign cap_status = cap_busy ? 2'b11 : 2'b00;

    always_ff @(posedge tck) begin
        if (trst) begin
            sr_q <= '0;
        end else if (en && capture) begin
            sr_q <= {cap_addr, cap_data, cap_status};
        end else if (en && shift) begin
            sr_q <= {tdi, sr_q[SR_W-1:1]};
        end
    end

    assign tdo = sr_q[0];
endmodule

// File: rtl/jdb_tck_ctrl.sv
`timescale 1ns/1ps
module jdb_tck_ctrl
    import jdb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64,
    localparam int SR_W  = 2 + DATA_W + ADDR_W
) (
    input  logic              tck,
    input  logic              trst,
    input  logic              en,
    input  logic              update,
    input  logic [SR_W-1:0]   sr_q,
    input  logic              ack_tgl_s,
    output logic              req_tgl,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              cmd_we,
    output logic              busy
);
    tck_state_e state, nxt;
    jdb_op_e    op;
    logic       launch;

    assign op     = jdb_op_e'(sr_q[1:0]);
    assign launch = (state == T_IDLE) && en && update &&
                    ((op == OP_RD) || (op == OP_WR));

    always_ff @(posedge tck) begin
        if (trst) state <= T_IDLE;
        else      state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            T_IDLE: if (launch) nxt = T_PEND;
            T_PEND: if (ack_tgl_s == req_tgl) nxt = T_IDLE;
        endcase
    end

    always_ff @(posedge tck) begin
        if (trst) begin
            req_tgl  <= 1'b0;
            cmd_addr <= '0;
            cmd_data <= '0;
            cmd_we   <= 1'b0;
        end else if (launch) begin
            req_tgl  <= ~req_tgl;
            cmd_addr <= sr_q[SR_W-1 -: ADDR_W];
            cmd_data <= sr_q[2 +: DATA_W];
            cmd_we   <= (op == OP_WR);
        end
    end

    assign busy = (state == T_PEND);
endmodule

// File: rtl/jdb_sys_ctrl.sv
`timescale 1ns/1ps
module jdb_sys_ctrl
    import jdb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 64
) (
    input  logic              sys_clk,
    input  logic              sys_rst,
    input  logic              req_tgl_s,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_we,
    output logic [ADDR_W-1:0] dbus_addr,
    output logic [DATA_W-1:0] dbus_wdata,
    output logic              dbus_we,
    output logic              dbus_req,
    input  logic [DATA_W-1:0] dbus_rdata,
    input  logic              dbus_ack,
    output logic              ack_tgl,
    output logic [DATA_W-1:0] resp_data
);
    sys_state_e state, nxt;
    logic       req_seen;
    logic       start;

    assign start = (req_tgl_s != req_seen);

    always_ff @(posedge sys_clk) begin
        if (sys_rst) state <= S_IDLE;
        else         state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start)    nxt = S_WAIT;
            S_WAIT:  if (dbus_ack) nxt = S_DONE;
            S_DONE:                nxt = S_IDLE;
            default:               nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            req_seen   <= 1'b0;
            dbus_addr  <= '0;
            dbus_wdata <= '0;
            dbus_we    <= 1'b0;
            dbus_req   <= 1'b0;
            ack_tgl    <= 1'b0;
            resp_data  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    req_seen   <= req_tgl_s;
                    dbus_addr  <= cmd_addr;
                    dbus_wdata <= cmd_data;
                    dbus_we    <= cmd_we;
                    dbus_req   <= 1'b1;
                end
                S_WAIT: if (dbus_ack) begin
                    dbus_req <= 1'b0;
                    if (!dbus_we) resp_data <= dbus_rdata;
                end
                S_DONE: ack_tgl <= ~ack_tgl;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/jtag_dbg_bridge.sv
`timescale 1ns/1ps
module jtag_dbg_bridge #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 64,
    parameter int          SEL_W    = 4,
    parameter logic [3:0]  CHAIN_ID = 4'd2,
    parameter int          SYNC_STG = 2,
    localparam int         SR_W     = 2 + DATA_W + ADDR_W
) (
    input  logic              tck,
    input  logic              trst,
    input  logic [SEL_W-1:0]  chain_sel,
    input  logic              capture,
    input  logic              shift,
    input  logic              update,
    input  logic              tdi,
    output logic              tdo,
    input  logic              sys_clk,
    input  logic              sys_rst,
    output logic [ADDR_W-1:0] dbus_addr,
    output logic [DATA_W-1:0] dbus_wdata,
    output logic              dbus_we,
    output logic              dbus_req,
    input  logic [DATA_W-1:0] dbus_rdata,
    input  logic              dbus_ack
);
    logic              sel_hit;
    logic [SR_W-1:0]   sr_q;
    logic              busy;
    logic              req_tgl, req_tgl_s;
    logic              ack_tgl, ack_tgl_s;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              cmd_we;
    logic [DATA_W-1:0] resp_data;

    assign sel_hit = (chain_sel == SEL_W'(CHAIN_ID));

    jdb_scan_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_scan (
        .tck      (tck),
        .trst     (trst),
        .en       (sel_hit),
        .capture  (capture),
        .shift    (shift),
        .tdi      (tdi),
        .cap_busy (busy),
        .cap_data (resp_data),
        .cap_addr (cmd_addr),
        .sr_q     (sr_q),
        .tdo      (tdo)
    );

    jdb_tck_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tck_ctrl (
        .tck       (tck),
        .trst      (trst),
        .en        (sel_hit),
        .update    (update),
        .sr_q      (sr_q),
        .ack_tgl_s (ack_tgl_s),
        .req_tgl   (req_tgl),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .cmd_we    (cmd_we),
        .busy      (busy)
    );

    jdb_sync #(.W(1), .STAGES(SYNC_STG)) u_req_sync (
        .clk (sys_clk),
        .rst (sys_rst),
        .d   (req_tgl),
        .q   (req_tgl_s)
    );

    jdb_sync #(.W(1), .STAGES(SYNC_STG)) u_ack_sync (
        .clk (tck),
        .rst (trst),
        .d   (ack_tgl),
        .q   (ack_tgl_s)
    );

    jdb_sys_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sys_ctrl (
        .sys_clk    (sys_clk),
        .sys_rst    (sys_rst),
        .req_tgl_s  (req_tgl_s),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .cmd_we     (cmd_we),
        .dbus_addr  (dbus_addr),
        .dbus_wdata (dbus_wdata),
        .dbus_we    (dbus_we),
        .dbus_req   (dbus_req),
        .dbus_rdata (dbus_rdata),
        .dbus_ack   (dbus_ack),
        .ack_tgl    (ack_tgl),
        .resp_data  (resp_data)
    );
endmodule

// File: rtl/jdb_bridge_chk.sv
`timescale 1ns/1ps
module jdb_bridge_chk #(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 64,
    parameter int         SEL_W    = 4,
    parameter logic [3:0] CHAIN_ID = 4'd2
) (
    input logic              tck,
    input logic              trst,
    input logic [SEL_W-1:0]  chain_sel,
    input logic              tdo,
    input logic              sys_clk,
    input logic              sys_rst,
    input logic [ADDR_W-1:0] dbus_addr,
    input logic [DATA_W-1:0] dbus_wdata,
    input logic              dbus_we,
    input logic              dbus_req,
    input logic              dbus_ack
);
    p_bus_hold_r8: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (dbus_req && !dbus_ack) |=> (dbus_req && $stable(dbus_addr) &&
                                     $stable(dbus_wdata) && $stable(dbus_we)));

    p_req_drop_r8: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (dbus_req && dbus_ack) |=> !dbus_req);

    p_foreign_chain_r5: assert property (@(posedge tck) disable iff (trst)
        (chain_sel != SEL_W'(CHAIN_ID)) |=> $stable(tdo));

    p_sys_reset_r9: assert property (@(posedge sys_clk)
        sys_rst |=> !dbus_req);

    p_tck_reset_r9: assert property (@(posedge tck)
        trst |=> !tdo);
endmodule

bind jtag_dbg_bridge jdb_bridge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .CHAIN_ID(CHAIN_ID)
) u_chk (
    .tck        (tck),
    .trst       (trst),
    .chain_sel  (chain_sel),
    .tdo        (tdo),
    .sys_clk    (sys_clk),
    .sys_rst    (sys_rst),
    .dbus_addr  (dbus_addr),
    .dbus_wdata (dbus_wdata),
    .dbus_we    (dbus_we),
    .dbus_req   (dbus_req),
    .dbus_ack   (dbus_ack)
);

// File: tb/jtag_dbg_bridge_bench.sv
`timescale 1ns/1ps
module jtag_dbg_bridge_bench;
    typedef struct {
        logic [7:0]  a;
        logic        we;
        logic [63:0] d;
    } exp_t;

    logic        tck = 1'b0;
    logic        trst;
    logic [3:0]  chain_sel;
    logic        capture, shift, update, tdi;
    logic        tdo;
    logic        sys_clk = 1'b0;
    logic        sys_rst;
    logic [7:0]  dbus_addr;
    logic [63:0] dbus_wdata;
    logic        dbus_we;
    logic        dbus_req;
    logic [63:0] dbus_rdata;
    logic        dbus_ack;

    int    n_chk = 0;
    int    n_bad = 0;
    int    unexp = 0;
    int    ack_delay = 3;
    string cur_tag = "R6";
    exp_t  exp_q[$];

    jtag_dbg_bridge u_jtag_dbg_bridge (
        .tck(tck), .trst(trst), .chain_sel(chain_sel), .capture(capture),
        .shift(shift), .update(update), .tdi(tdi), .tdo(tdo),
        .sys_clk(sys_clk), .sys_rst(sys_rst), .dbus_addr(dbus_addr),
        .dbus_wdata(dbus_wdata), .dbus_we(dbus_we), .dbus_req(dbus_req),
        .dbus_rdata(dbus_rdata), .dbus_ack(dbus_ack)
    );

    always #5 sys_clk = ~sys_clk;

    function automatic logic [63:0] rd_model(input logic [7:0] a);
        return {8{a}} ^ 64'h0123_4567_89ab_cdef;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tck_cycle();
        #15 tck = 1'b1;
        #15 tck = 1'b0;
    endtask

    task automatic scan(input logic [73:0] vin, output logic [73:0] vout);
        capture = 1'b1;
        tck_cycle();
        capture = 1'b0;
        shift   = 1'b1;
        for (int i = 0; i < 74; i++) begin
            tdi     = vin[i];
            vout[i] = tdo;
            tck_cycle();
        end
        shift  = 1'b0;
        update = 1'b1;
        tck_cycle();
        update = 1'b0;
        tck_cycle();
    endtask

    task automatic send(input logic [1:0] op, input logic [7:0] a,
                        input logic [63:0] d, input bit expect_bus,
                        output logic [73:0] vout);
        exp_t e;
        if (expect_bus) begin
            e.a = a; e.we = (op == 2'b10); e.d = d;
            exp_q.push_back(e);
        end
        scan({a, d, op}, vout);
    endtask

    task automatic poll(input string tag, output logic [73:0] vout);
        logic [73:0] v;
        v = '1;
        for (int k = 0; k < 40; k++) begin
            scan(74'd0, v);
            if (v[1:0] == 2'b00) break;
        end
        chk(v[1:0] == 2'b00, tag, 64'(v[1:0]), 64'd0);
        vout = v;
    endtask

    // bus model and scoreboard monitor
    initial begin
        exp_t        e;
        logic [7:0]  a0;
        logic [63:0] d0;
        logic        w0;
        dbus_ack   = 1'b0;
        dbus_rdata = '0;
        forever begin
            @(negedge sys_clk);
            if (!sys_rst && dbus_req) begin
                a0 = dbus_addr; d0 = dbus_wdata; w0 = dbus_we;
                if (exp_q.size() == 0) begin
                    unexp++;
                    chk(1'b0, {cur_tag, " unexpected request"}, 64'(a0), 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    chk(a0 == e.a, "R2 bus address", 64'(a0), 64'(e.a));
                    chk(w0 == e.we, "R2 bus write flag", 64'(w0), 64'(e.we));
                    if (e.we) chk(d0 == e.d, "R10 bus write data", d0, e.d);
                end
                repeat (ack_delay) @(negedge sys_clk);
                chk(dbus_req && dbus_addr == a0 && dbus_wdata == d0 && dbus_we == w0,
                    "R8 held until ack", 64'(dbus_addr), 64'(a0));
                dbus_rdata = rd_model(a0);
                dbus_ack   = 1'b1;
                @(negedge sys_clk);
                dbus_ack = 1'b0;
                chk(!dbus_req, "R8 request drops after ack", 64'(dbus_req), 64'd0);
            end
        end
    end

    // watchdog
    initial begin
        #1500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [73:0] v;
        logic        t0;
        bit          same;
        trst = 1'b1; sys_rst = 1'b1; chain_sel = 4'd2;
        capture = 1'b0; shift = 1'b0; update = 1'b0; tdi = 1'b0;
        repeat (4) tck_cycle();
        repeat (4) @(posedge sys_clk);
        trst = 1'b0;
        @(negedge sys_clk);
        sys_rst = 1'b0;
        #2;
        chk(tdo == 1'b0, "R9 tdo after trst", 64'(tdo), 64'd0);
        chk(dbus_req == 1'b0, "R9 no request after sys_rst", 64'(dbus_req), 64'd0);

        // status scan after reset
        cur_tag = "R6";
        send(2'b00, 8'h00, 64'd0, 1'b0, v);
        chk(v[1:0] == 2'b00, "R3 idle status after reset", 64'(v[1:0]), 64'd0);
        chk(v[65:2] == 64'd0, "R9 data cleared", v[65:2], 64'd0);

        // write
        send(2'b10, 8'h05, 64'hfeed_0000_cafe_1234, 1'b1, v);
        poll("R2 write completes", v);
        chk(v[73:66] == 8'h05, "R1 address field order", 64'(v[73:66]), 64'h05);

        // reads with distinct patterns
        send(2'b01, 8'h11, 64'd0, 1'b1, v);
        poll("R2 read completes", v);
        chk(v[65:2] == rd_model(8'h11), "R10 read data 0x11", v[65:2], rd_model(8'h11));
        chk(v[73:66] == 8'h11, "R1 address field after read", 64'(v[73:66]), 64'h11);
        send(2'b01, 8'h7e, 64'hffff_ffff_ffff_ffff, 1'b1, v);
        poll("R3 read completes", v);
        chk(v[65:2] == rd_model(8'h7e), "R3 read data 0x7e", v[65:2], rd_model(8'h7e));

        // ignored op 11
        send(2'b11, 8'h44, 64'h1, 1'b0, v);
        repeat (30) @(negedge sys_clk);
        chk(unexp == 0, "R6 op 11 launches nothing", 64'(unexp), 64'd0);
        scan(74'd0, v);
        chk(v[73:66] == 8'h7e, "R6 last address kept", 64'(v[73:66]), 64'h7e);

        // foreign chain
        cur_tag = "R5";
        chain_sel = 4'd3;
        tck_cycle();
        t0 = tdo;
        scan({8'h33, 64'h5555_aaaa_5555_aaaa, 2'b10}, v);
        same = (v == {74{t0}}) && (tdo == t0);
        chk(same, "R5 tdo frozen on foreign chain", 64'(v[63:0]), {64{t0}});
        repeat (30) @(negedge sys_clk);
        chk(unexp == 0, "R5 no request on foreign chain", 64'(unexp), 64'd0);
        chain_sel = 4'd2;
        tck_cycle();
        scan(74'd0, v);
        chk(v[73:66] == 8'h7e, "R5 update ignored on foreign chain", 64'(v[73:66]), 64'h7e);

        // busy window
        cur_tag = "R7";
        ack_delay = 1000;
        send(2'b10, 8'h9c, 64'h0bad_f00d_1357_2468, 1'b1, v);
        send(2'b00, 8'h00, 64'd0, 1'b0, v);
        chk(v[1:0] == 2'b11, "R4 busy status", 64'(v[1:0]), 64'h3);
        send(2'b10, 8'h21, 64'h1111, 1'b0, v);
        chk(v[1:0] == 2'b11, "R7 still busy", 64'(v[1:0]), 64'h3);
        poll("R4 busy clears", v);
        chk(v[73:66] == 8'h9c, "R7 second command dropped", 64'(v[73:66]), 64'h9c);
        repeat (40) @(negedge sys_clk);
        chk(unexp == 0, "R7 no request from busy update", 64'(unexp), 64'd0);
        chk(exp_q.size() == 0, "R2 all commands seen", 64'(exp_q.size()), 64'd0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule